// File: doc/BRIEF.md
# One-Hot Multi-State Sample Gate

This block sits behind a group of parallel stochastic bit sources that together form one multi-state node. The node has `NSTATE` possible states. Each state is held as a one-hot vector, and each source belongs to one state. On every sampling strobe the gate inspects the binarized source bits.

- When exactly one source fired, the node moves to that source's state.
- When no source fired, or two or more fired at once, the node keeps its last valid state.
- A collision is never resolved by priority.

Because valid samples arrive at random strobes, nodes driven from a common clock update at random, uncorrelated times.

An iteration is a window of up to `win_len` strobes. The window ends early on the first valid sample, so a node changes state at most once per iteration. The window also ends when its strobe budget runs out without a valid sample. Either way, `iter_done` pulses once. A longer window lets more nodes change per iteration. A window of one strobe leaves most nodes where they are.

Top module: `onehot_sample_gate`

## Requirements
- R1: In the cycle after a synchronous reset, `state_oh` has only bit 0 set, `state_idx` is 0, and `upd_pulse`, `coll_pulse` and `iter_done` are all 0.
- R2: After reset, `state_oh` always has exactly one bit set, and `state_idx` equals the position of that bit.
- R3: A strobe with exactly one `fire` bit k set makes `state_oh` equal to `1 << k` and `state_idx` equal to k in the next cycle, with `upd_pulse` high for that one cycle.
- R4: A strobe with two or more `fire` bits set leaves `state_oh` and `state_idx` unchanged, and raises `coll_pulse` for one cycle with `upd_pulse` low.
- R5: A strobe with no `fire` bit set leaves the state unchanged, with `upd_pulse` and `coll_pulse` low.
- R6: In a cycle without a strobe, `fire` is ignored. The state does not change and all three pulses are low in the next cycle.
- R7: The strobe count restarts after each `iter_done`. `iter_done` pulses in the cycle after a strobe that either carries a valid single-source sample, or is the `win_len`-th strobe since the last restart. A `win_len` of 0 acts as 1.
- R8: The state count is a parameter, and values from 3 to 10 work. `state_idx` is ceil(log2 `NSTATE`) bits wide. With `NSTATE` = 10, a lone fire on bit 9 gives index 9, and a collision still holds the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | One-cycle sampling strobe |
| fire | input | NSTATE | Binarized source bits, one per state |
| win_len | input | WIN_W | Strobes per iteration window (0 acts as 1) |
| state_oh | output | NSTATE | Current one-hot node state |
| state_idx | output | IDX_W | Index of the set bit of `state_oh` |
| upd_pulse | output | 1 | State replaced by a valid sample |
| coll_pulse | output | 1 | Two or more sources fired on the strobe |
| iter_done | output | 1 | Iteration window closed |

## Verification
The hardest situation to reach is a window that expires exactly on its last strobe, right after a run of collisions and empty samples. Both must be frequent while lone fires stay rare.

The stimulus sets each source bit with a chosen probability per phase. A low firing probability gives mostly empty samples, and a high one gives mostly collisions. Both phases run against several window lengths, including 0 and 1, and `win_len` is also changed partway through an open window.

// File: rtl/onehot_gate_pkg.sv
package onehot_gate_pkg;
    typedef enum logic [1:0] {
        FIRE_NONE = 2'd0,
        FIRE_ONE  = 2'd1,
        FIRE_MANY = 2'd2
    } fire_kind_e;
endpackage

// File: rtl/fire_classify.sv
module fire_classify
    import onehot_gate_pkg::*;
#(
    parameter int NSTATE = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NSTATE-1:0] fire,
    output fire_kind_e        kind,
    output logic [IDX_W-1:0]  lone_idx
);
    localparam int CNT_W = $clog2(NSTATE + 1);

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones     = '0;
        lone_idx = '0;
        for (int i = 0; i < NSTATE; i++) begin
            if (fire[i]) begin
                ones     = ones + CNT_W'(1);
                lone_idx = IDX_W'(i);
            end
        end
        if (ones == '0)
            kind = FIRE_NONE;
        else if (ones == CNT_W'(1))
            kind = FIRE_ONE;
        else
            kind = FIRE_MANY;
    end
endmodule

// File: rtl/sample_window_ctr.sv
module sample_window_ctr #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             hit,
    input  logic [WIN_W-1:0] win_len,
    output logic             expire
);
    logic [WIN_W-1:0] count_d, count_q;
    logic [WIN_W:0]   eff_len;
    logic             last;

    always_comb begin
        eff_len = (win_len == '0) ? (WIN_W+1)'(1) : {1'b0, win_len};
        last    = ({1'b0, count_q} + (WIN_W+1)'(1)) >= eff_len;
        expire  = strobe && !hit && last;
        count_d = count_q;
        if (strobe) begin
            if (hit || last)
                count_d = '0;
            else
                count_d = count_q + WIN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else
            count_q <= count_d;
    end

    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe && hit) |=> (count_q == '0));
endmodule

// File: rtl/onehot_sample_gate.sv
module onehot_sample_gate
    import onehot_gate_pkg::*;
#(
    parameter int NSTATE = 4,
    parameter int WIN_W  = 8,
    parameter int IDX_W  = (NSTATE > 1) ? $clog2(NSTATE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [NSTATE-1:0] fire,
    input  logic [WIN_W-1:0]  win_len,
    output logic [NSTATE-1:0] state_oh,
    output logic [IDX_W-1:0]  state_idx,
    output logic              upd_pulse,
    output logic              coll_pulse,
    output logic              iter_done
);
    typedef struct packed {
        logic [NSTATE-1:0] oh;
        logic [IDX_W-1:0]  idx;
        logic              upd;
        logic              coll;
        logic              done;
    } gate_regs_t;

    gate_regs_t  r_d, r_q;
    fire_kind_e  kind;
    logic [IDX_W-1:0] lone_idx;
    logic        hit;
    logic        expire;

    fire_classify #(.NSTATE(NSTATE), .IDX_W(IDX_W)) u_cls (
        .fire     (fire),
        .kind     (kind),
        .lone_idx (lone_idx)
    );

    assign hit = strobe && (kind == FIRE_ONE);

    sample_window_ctr #(.WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .hit     (hit),
        .win_len (win_len),
        .expire  (expire)
    );

    always_comb begin
        r_d      = r_q;
        r_d.upd  = 1'b0;
        r_d.coll = 1'b0;
        r_d.done = 1'b0;
        if (strobe) begin
            r_d.coll = (kind == FIRE_MANY);
            if (hit) begin
                r_d.oh  = fire;
                r_d.idx = lone_idx;
                r_d.upd = 1'b1;
            end
            r_d.done = hit || expire;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q      <= '0;
            r_q.oh   <= NSTATE'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign state_oh   = r_q.oh;
    assign state_idx  = r_q.idx;
    assign upd_pulse  = r_q.upd;
    assign coll_pulse = r_q.coll;
    assign iter_done  = r_q.done;

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot(state_oh));
    p_lone_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe && $onehot(fire)) |=> (state_oh == $past(fire)) && upd_pulse);
    p_many_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe && ($countones(fire) >= 2)) |=> $stable(state_oh) && coll_pulse && !upd_pulse);
    p_none_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe && (fire == '0)) |=> $stable(state_oh) && !upd_pulse && !coll_pulse);
    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(state_oh) && !upd_pulse && !coll_pulse && !iter_done);
    p_upd_done_r7: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> iter_done);
endmodule

// File: tb/sim_onehot_sample_gate.sv
module sim_onehot_sample_gate;
    localparam int NS = 4;
    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe = 1'b0;
    logic [NS-1:0] fire = '0;
    logic [WW-1:0] win_len = 8'd1;
    logic [NS-1:0] state_oh;
    logic [1:0]    state_idx;
    logic          upd_pulse, coll_pulse, iter_done;

    logic          strobe10 = 1'b0;
    logic [9:0]    fire10 = '0;
    logic [9:0]    oh10;
    logic [3:0]    idx10;
    logic          upd10, coll10, done10;

    int n_tests = 0;
    int n_fail  = 0;
    int m_st    = 0;
    int m_cnt   = 0;

    always #2 clk = ~clk;

    onehot_sample_gate #(.NSTATE(NS), .WIN_W(WW)) u0 (
        .clk(clk), .rst(rst), .strobe(strobe), .fire(fire), .win_len(win_len),
        .state_oh(state_oh), .state_idx(state_idx), .upd_pulse(upd_pulse),
        .coll_pulse(coll_pulse), .iter_done(iter_done));

    onehot_sample_gate #(.NSTATE(10), .WIN_W(WW)) u1 (
        .clk(clk), .rst(rst), .strobe(strobe10), .fire(fire10), .win_len(8'd1),
        .state_oh(oh10), .state_idx(idx10), .upd_pulse(upd10),
        .coll_pulse(coll10), .iter_done(done10));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit s, input logic [NS-1:0] f);
        int  n;
        int  k;
        int  eff;
        bit  e_upd, e_coll, e_done;
        string tag;
        @(negedge clk);
        strobe = s;
        fire   = f;
        n = $countones(f);
        k = 0;
        for (int i = 0; i < NS; i++) if (f[i]) k = i;
        e_upd = 0; e_coll = 0; e_done = 0;
        tag = "R6";
        if (s) begin
            eff = (win_len == 0) ? 1 : int'(win_len);
            if (n == 1) begin
                tag = "R3"; m_st = k; e_upd = 1; e_done = 1; m_cnt = 0;
            end else begin
                tag = (n >= 2) ? "R4" : "R5";
                e_coll = (n >= 2);
                if (m_cnt + 1 >= eff) begin
                    e_done = 1; m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
        end
        @(posedge clk);
        #1;
        chk(state_oh == NS'(1 << m_st) && int'(state_idx) == m_st, tag,
            int'(state_oh), 1 << m_st);
        chk(upd_pulse == e_upd && coll_pulse == e_coll, tag,
            {upd_pulse, coll_pulse}, {e_upd, e_coll});
        chk(iter_done == e_done, "R7", iter_done, e_done);
        chk($onehot(state_oh), "R2", int'(state_oh), 1 << m_st);
    endtask

    function automatic logic [NS-1:0] rnd_fire(input int pct);
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++) v[i] = (($urandom % 100) < pct);
        return v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0;
        // R1: reset state, sampled before any strobe takes effect
        chk(state_oh == 4'b0001 && state_idx == 0, "R1", int'(state_oh), 1);
        chk(!upd_pulse && !coll_pulse && !iter_done, "R1",
            {upd_pulse, coll_pulse, iter_done}, 0);

        // directed: R3 lone fire, R4 collision hold, R5 empty hold, R6 no strobe
        win_len = 8'd1;
        step(1, 4'b0100);
        step(1, 4'b1010);
        step(1, 4'b0000);
        step(0, 4'b0001);
        step(0, 4'b1111);
        step(1, 4'b1000);
        step(1, 4'b0001);
        // R7: window of 3 with no valid sample, then early end on valid sample
        win_len = 8'd3;
        step(1, 4'b0000);
        step(0, 4'b0000);
        step(1, 4'b0011);
        step(1, 4'b0000);
        step(1, 4'b0000);
        step(1, 4'b0010);
        // R7: win_len 0 acts as 1
        win_len = 8'd0;
        step(1, 4'b0000);
        step(1, 4'b1100);

        // random phases: sparse firing, dense firing, across window lengths
        for (int ph = 0; ph < 8; ph++) begin
            int pct;
            pct = (ph % 2 == 0) ? 8 : 65;
            win_len = WW'((ph * 3) % 7);
            for (int c = 0; c < 1500; c++) begin
                if (c == 700) win_len = WW'(ph % 3 + 1);
                step((($urandom % 10) < 7), rnd_fire(pct));
            end
        end

        // R8: ten-state instance
        @(negedge clk);
        chk(idx10 == 0 && oh10 == 10'h001, "R8", int'(idx10), 0);
        strobe10 = 1'b1; fire10 = 10'h200;
        @(posedge clk); #1;
        chk(idx10 == 9 && oh10 == 10'h200 && upd10, "R8", int'(idx10), 9);
        @(negedge clk);
        fire10 = 10'h084;
        @(posedge clk); #1;
        chk(idx10 == 9 && oh10 == 10'h200 && coll10 && !upd10, "R8", int'(oh10), 10'h200);
        @(negedge clk);
        strobe10 = 1'b0; fire10 = 10'h001;
        @(posedge clk); #1;
        chk(idx10 == 9 && !done10, "R8", int'(idx10), 9);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule